// File: doc/BRIEF.md
# Saturating Q15 Complex Vector Multiplier

This block is a streaming datapath that multiplies complex numbers lane by lane. Every operand and result is a pair of signed 16-bit Q15 values. Each beat on the input stream carries one operand vector `a` and one operand vector `b`, with `LANES` complex elements in each. Lane k of the result is `a[k] * b[k]`, where the complex product is formed in a specific order. Each of the four cross products is rounded and scaled to Q15 on its own. The real and imaginary parts are then formed from those rounded partials. Only the final sum or difference is clamped to the 16-bit range.

A per-lane enable mask comes with every beat. A lane that is switched off produces zero, and it does not disturb its neighbours. Each result lane also carries a flag that says whether either of its parts was clamped. The pipeline has three register stages: products, rounding, then combine and saturate. The whole pipeline moves only when the consumer is ready, so the block applies backpressure by holding every stage in place.

Top module: `cq15_vmul`

## Requirements
- R1: Lane k occupies bits [32k+31:32k] of `in_a`, `in_b` and `out_c`. The real part sits in the low 16 bits of the lane and the imaginary part in the high 16 bits, each in two's complement Q15.
- R2: Each signed 16x16 cross product is formed at 32-bit precision. 16384 is added to it, and it is arithmetically shifted right by 15 on its own, before any sum or difference is taken (for example, rnd(-16384) = 0 and rnd(16384) = 1).
- R3: The real result is rnd(a.re*b.re) - rnd(a.im*b.im).
- R4: The imaginary result is rnd(a.re*b.im) + rnd(a.im*b.re).
- R5: A combined value above 32767 becomes 0x7FFF, and a value below -32768 becomes 0x8000. Any other value is output unchanged. The lane's `out_sat` bit is 1 exactly when either part of that lane was clamped.
- R6: The product -32768 x -32768 rounds to +32768. With a zero second partial, the result is 0x7FFF with `out_sat` set.
- R7: A lane whose `in_mask` bit is 0 outputs 0x00000000 with `out_sat` 0, and the other lanes are computed as if it were enabled.
- R8: With `out_ready` held high, a beat accepted on a rising edge is presented on `out_c` with `out_valid` high after the second edge that follows it. Back-to-back beats leave in order, one per cycle. `in_ready` equals `out_ready`.
- R9: While `out_ready` is low, no stage advances. `in_ready` is low, and `out_valid`, `out_c` and `out_sat` hold their values.
- R10: After a synchronous active-high reset, `out_valid` is 0, `out_c` is 0 and `out_sat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_a | input | 32*LANES | Operand vector a, one complex element per lane |
| in_b | input | 32*LANES | Operand vector b, one complex element per lane |
| in_mask | input | LANES | Per-lane enable for the beat |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer accepts the result |
| out_c | output | 32*LANES | Result vector, one complex element per lane |
| out_sat | output | LANES | Per-lane clamp indicator |

## Verification
The bench builds the block with the default of four lanes. This width is enough to put an ordinary lane, a clamping lane, the -32768 squared corner and a masked lane side by side in one beat. With these lanes the bench can show that masking and saturation stay local to their own lane. Directed beats pick operands whose per-partial rounding gives a different answer from a single final rounding, and that proves the rounding order. Stall and streaming scenarios then check the fixed three-edge latency, the ordering, and the held output while the consumer is not ready.

// File: rtl/cq15_pkg.sv
`timescale 1ns/1ps
package cq15_pkg;

    // One complex Q15 element; real part in the low half of the word.
    typedef struct packed {
        logic signed [15:0] im;
        logic signed [15:0] re;
    } cplx_t;

    // Four full-precision cross products of one lane.
    typedef struct packed {
        logic signed [31:0] rr;
        logic signed [31:0] ii;
        logic signed [31:0] ri;
        logic signed [31:0] ir;
    } prod_t;

    // Four rounded Q15 partials; 17 bits since +32768 is reachable.
    typedef struct packed {
        logic signed [16:0] rr;
        logic signed [16:0] ii;
        logic signed [16:0] ri;
        logic signed [16:0] ir;
    } part_t;

    typedef struct packed {
        logic        clamped;
        logic [15:0] val;
    } sat_t;

    localparam int unsigned PROD_W = 32;
    localparam int unsigned PART_W = 17;
    localparam int unsigned SUM_W  = PART_W + 1;
    localparam logic signed [PROD_W-1:0] RND_BIAS = 32'sd16384;

    // Round a Q30 product to Q15: add half an LSB, keep bits 31..15.
    function automatic logic signed [PART_W-1:0] rnd_q15(input logic signed [PROD_W-1:0] p);
        logic signed [PROD_W-1:0] t;
        t = p + RND_BIAS;
        return t[PROD_W-1:15];
    endfunction

    // Clamp an 18-bit combined value to the signed 16-bit range.
    function automatic sat_t sat16(input logic signed [SUM_W-1:0] v);
        sat_t r;
        if (v > 18'sd32767) begin
            r.clamped = 1'b1;
            r.val     = 16'h7FFF;
        end else if (v < -18'sd32768) begin
            r.clamped = 1'b1;
            r.val     = 16'h8000;
        end else begin
            r.clamped = 1'b0;
            r.val     = v[15:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/cq15_pipe_ctrl.sv
`timescale 1ns/1ps
module cq15_pipe_ctrl #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic adv,
    output logic out_valid
);
    logic [STAGES-1:0] vld;

    assign adv       = out_ready;
    assign in_ready  = out_ready;
    assign out_valid = vld[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else if (adv) begin
            vld <= {vld[STAGES-2:0], in_valid};
        end
    end

    assert_reset_idle_R10: assert property (@(posedge clk) rst |=> !out_valid)
        else $error("reset did not clear output valid");

    assert_hold_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid)
        else $error("valid dropped while stalled");

endmodule

// File: rtl/cq15_lane.sv
`timescale 1ns/1ps
module cq15_lane
    import cq15_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  mask_i,
    input  cplx_t a_i,
    input  cplx_t b_i,
    output cplx_t res_o,
    output logic  sat_o
);
    // Stage 1: full-precision products
    prod_t prod_n, prod_q;
    logic  en1_q;

    always_comb begin
        prod_n.rr = a_i.re * b_i.re;
        prod_n.ii = a_i.im * b_i.im;
        prod_n.ri = a_i.re * b_i.im;
        prod_n.ir = a_i.im * b_i.re;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            en1_q  <= 1'b0;
        end else if (adv) begin
            en1_q  <= mask_i;
            prod_q <= mask_i ? prod_n : '0;
        end
    end

    // Stage 2: independent rounding of each partial
    part_t part_q;
    logic  en2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
            en2_q  <= 1'b0;
        end else if (adv) begin
            en2_q     <= en1_q;
            part_q.rr <= rnd_q15(prod_q.rr);
            part_q.ii <= rnd_q15(prod_q.ii);
            part_q.ri <= rnd_q15(prod_q.ri);
            part_q.ir <= rnd_q15(prod_q.ir);
        end
    end

    // Stage 3: combine at 18 bits, then clamp
    logic signed [SUM_W-1:0] re_sum, im_sum;
    sat_t re_sat, im_sat;
    logic en3_q;

    always_comb begin
        re_sum = SUM_W'(part_q.rr) - SUM_W'(part_q.ii);
        im_sum = SUM_W'(part_q.ri) + SUM_W'(part_q.ir);
        re_sat = sat16(re_sum);
        im_sat = sat16(im_sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o <= '0;
            sat_o <= 1'b0;
            en3_q <= 1'b0;
        end else if (adv) begin
            en3_q    <= en2_q;
            res_o.re <= re_sat.val;
            res_o.im <= im_sat.val;
            sat_o    <= re_sat.clamped | im_sat.clamped;
        end
    end

    assert_partial_range_R2: assert property (@(posedge clk) disable iff (rst)
        (part_q.rr >= -17'sd32768) && (part_q.rr <= 17'sd32768) &&
        (part_q.ii >= -17'sd32768) && (part_q.ii <= 17'sd32768))
        else $error("rounded partial out of Q15 range");

    assert_sat_code_R5: assert property (@(posedge clk) disable iff (rst)
        sat_o |-> (res_o.re == 16'sh7FFF || res_o.re == -16'sh8000 ||
                   res_o.im == 16'sh7FFF || res_o.im == -16'sh8000))
        else $error("clamp flag without a clamped value");

    assert_mask_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !en3_q |-> (res_o == '0 && !sat_o))
        else $error("disabled lane produced data");

endmodule

// File: rtl/cq15_vmul.sv
`timescale 1ns/1ps
module cq15_vmul
    import cq15_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [32*LANES-1:0]   in_a,
    input  logic [32*LANES-1:0]   in_b,
    input  logic [LANES-1:0]      in_mask,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [32*LANES-1:0]   out_c,
    output logic [LANES-1:0]      out_sat
);
    localparam int unsigned ELEM_W = $bits(cplx_t);
    localparam int unsigned DEPTH  = 3;

    logic adv;

    cq15_pipe_ctrl #(.STAGES(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .adv       (adv),
        .out_valid (out_valid)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        cplx_t a_k, b_k, c_k;
        assign a_k = in_a[ELEM_W*k +: ELEM_W];
        assign b_k = in_b[ELEM_W*k +: ELEM_W];
        assign out_c[ELEM_W*k +: ELEM_W] = c_k;

        cq15_lane lane_i (
            .clk    (clk),
            .rst    (rst),
            .adv    (adv),
            .mask_i (in_mask[k]),
            .a_i    (a_k),
            .b_i    (b_k),
            .res_o  (c_k),
            .sat_o  (out_sat[k])
        );
    end

    assert_hold_data_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> ($stable(out_c) && $stable(out_sat)))
        else $error("result changed while stalled");

    assert_ready_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> out_ready)
        else $error("beat accepted without downstream ready");

endmodule

// File: tb/cq15_vmul_tb.sv
`timescale 1ns/1ps
module cq15_vmul_tb_top;
    localparam int L = 4;
    localparam int W = 32 * L;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic [L-1:0] in_mask = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [W-1:0] out_c;
    logic [L-1:0] out_sat;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cq15_vmul #(.LANES(L)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_mask(in_mask),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_c(out_c), .out_sat(out_sat)
    );

    function automatic logic [31:0] pk(input int re, input int im);
        logic [31:0] w;
        w = {im[15:0], re[15:0]};
        return w;
    endfunction

    function automatic int clampv(input int v, output bit hit);
        hit = 1'b1;
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        hit = 1'b0;
        return v;
    endfunction

    // Returns {sat, im, re} per the requirements
    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
        int ar, ai, br, bi, r_rr, r_ii, r_ri, r_ir, re, im;
        bit h1, h2;
        ar = int'($signed(a[15:0]));  ai = int'($signed(a[31:16]));
        br = int'($signed(b[15:0]));  bi = int'($signed(b[31:16]));
        r_rr = (ar * br + 16384) >>> 15;
        r_ii = (ai * bi + 16384) >>> 15;
        r_ri = (ar * bi + 16384) >>> 15;
        r_ir = (ai * br + 16384) >>> 15;
        re = clampv(r_rr - r_ii, h1);
        im = clampv(r_ri + r_ir, h2);
        return {(h1 | h2), im[15:0], re[15:0]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_lanes(input string req, input logic [W-1:0] a,
                               input logic [W-1:0] b, input logic [L-1:0] m);
        for (int k = 0; k < L; k++) begin
            logic [32:0] e;
            e = m[k] ? model(a[32*k +: 32], b[32*k +: 32]) : 33'd0;
            chk($sformatf("%s lane%0d data", req, k), 64'(out_c[32*k +: 32]), 64'(e[31:0]));
            chk($sformatf("%s lane%0d sat", req, k), 64'(out_sat[k]), 64'(e[32]));
        end
    endtask

    // Drive one beat, wait for it to reach the output (ready held high)
    task automatic send_beat(input logic [W-1:0] a, input logic [W-1:0] b, input logic [L-1:0] m);
        @(negedge clk);
        in_a = a; in_b = b; in_mask = m; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_a = '0; in_b = '0; in_mask = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 out_valid after three edges", 64'(out_valid), 64'd1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 out_valid in reset", 64'(out_valid), 64'd0);
        chk("R10 out_c in reset", 64'(out_c), 64'd0);
        chk("R10 out_sat in reset", 64'(out_sat), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 in_ready follows out_ready", 64'(in_ready), 64'd1);
    endtask

    task automatic t_basic;
        logic [W-1:0] a, b;
        a = {pk(100, -200), pk(-12345, 6789), pk(16384, 16384), pk(1, 1)};
        b = {pk(-3000, 4000), pk(23456, -1111), pk(16384, -16384), pk(16384, -16384)};
        send_beat(a, b, 4'hF);
        check_lanes("R3 R4 basic", a, b, 4'hF);
        // per-partial rounding: rnd(-16384)+rnd(16384) = 0+1, single rounding would give 0
        chk("R2 separate rounding imag", 64'(out_c[31:16]), 64'h0001);
        chk("R1 real in low half", 64'(out_c[15:0]), 64'h0001);
        a = {pk(32767, 0), pk(0, 32767), pk(-1, -1), pk(7, -9)};
        b = {pk(32767, 0), pk(0, 32767), pk(-1, 1), pk(-32768, 32767)};
        send_beat(a, b, 4'hF);
        check_lanes("R3 R4 second pattern", a, b, 4'hF);
    endtask

    task automatic t_sat;
        logic [W-1:0] a, b;
        a = {pk(32767, 32767), pk(-32768, 32767), pk(-32768, -32768), pk(20000, 20000)};
        b = {pk(32767, 32767), pk(32767, 32767), pk(-32768, 32767), pk(20000, -20000)};
        send_beat(a, b, 4'hF);
        check_lanes("R5 saturation", a, b, 4'hF);
        chk("R5 imag clamps high", 64'(out_c[127:112]), 64'h7FFF);
        chk("R5 real clamps low", 64'(out_c[79:64]), 64'h8000);
        chk("R5 sat flags", 64'(out_sat), 64'hE);
    endtask

    task automatic t_corner;
        logic [W-1:0] a, b;
        a = {pk(5, 5), pk(5, 5), pk(5, 5), pk(-32768, 0)};
        b = {pk(5, 5), pk(5, 5), pk(5, 5), pk(-32768, 0)};
        send_beat(a, b, 4'hF);
        chk("R6 corner real", 64'(out_c[15:0]), 64'h7FFF);
        chk("R6 corner imag", 64'(out_c[31:16]), 64'h0000);
        chk("R6 corner sat", 64'(out_sat[0]), 64'd1);
    endtask

    task automatic t_mask;
        logic [W-1:0] a, b;
        a = {pk(-32768, 0), pk(1234, -4321), pk(32767, 32767), pk(-500, 700)};
        b = {pk(-32768, 0), pk(-999, 888), pk(32767, 32767), pk(321, -123)};
        send_beat(a, b, 4'b0101);
        check_lanes("R7 mask 0101", a, b, 4'b0101);
        send_beat(a, b, 4'b1010);
        check_lanes("R7 mask 1010", a, b, 4'b1010);
    endtask

    task automatic t_stall;
        logic [W-1:0] a, b;
        logic [W-1:0] held;
        a = {pk(300, 400), pk(-32768, 0), pk(1000, -1000), pk(32767, -32768)};
        b = {pk(-700, 800), pk(-32768, 0), pk(2000, 3000), pk(32767, 32767)};
        @(negedge clk);
        out_ready = 1'b1;
        in_a = a; in_b = b; in_mask = 4'hF; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
        chk("R9 in_ready low when stalled", 64'(in_ready), 64'd0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R9 no advance while stalled", 64'(out_valid), 64'd0);
        out_ready = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 valid after stall resumes", 64'(out_valid), 64'd1);
        check_lanes("R8 data after stall", a, b, 4'hF);
        held = out_c;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 valid held", 64'(out_valid), 64'd1);
        chk("R9 data held", 64'(out_c == held), 64'd1);
        check_lanes("R9 flags held", a, b, 4'hF);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 drained", 64'(out_valid), 64'd0);
    endtask

    task automatic t_stream;
        localparam int N = 6;
        logic [W-1:0] sa [N];
        logic [W-1:0] sb [N];
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < L; k++) begin
                sa[i][32*k +: 32] = pk(i * 5011 - k * 9973, 30000 - i * 7919 + k * 101);
                sb[i][32*k +: 32] = pk(-32768 + i * 12007 + k * 3, i * 4099 - k * 20011);
            end
        end
        out_ready = 1'b1;
        for (int t = 0; t < N + 3; t++) begin
            @(negedge clk);
            if (t >= 3) begin
                chk("R8 stream valid", 64'(out_valid), 64'd1);
                check_lanes("R8 stream order", sa[t-3], sb[t-3], 4'hF);
            end
            if (t < N) begin
                in_a = sa[t]; in_b = sb[t]; in_mask = 4'hF; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(posedge clk);
        end
        @(negedge clk);
        chk("R8 stream ends", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_sat();
        t_corner();
        t_mask();
        t_stall();
        t_stream();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule